// File: doc/BRIEF.md
# PWM Channel Counter and Comparator

This block is one channel of a pulse-width modulation controller. A shared prescaler supplies a vector of clock-enable taps, where tap k pulses once every 2^k master-clock cycles. The channel picks one tap with its clock-select input and runs a 16-bit counter only on cycles where that tap is high. It compares the counter with an active duty value to drive the waveform output, and it compares the counter with an active period value to decide when the counter turns around or wraps. A controller is built from four identical copies of this block.

Two alignments are supported. In left-aligned mode the counter ramps up and wraps to zero. In center-aligned mode it ramps up to the period value and back down to zero. The period, duty and alignment inputs are sampled only at a period boundary, so a change made mid-period never produces a partial cycle. The output polarity input sets which level the output takes during the active part of the cycle. A one-cycle period-end strobe marks every boundary.

Top module: `pwm_chan`

## Requirements
- R1: While reset is held, and afterwards until the first period boundary, the active duty is zero and the output equals the inverse of the polarity input.
- R2: The counter and output advance only on master-clock cycles where the tap chosen by the clock-select input is high (select value k picks tap k). A select value at or above the number of taps stops the channel: no period-end strobes occur and the output holds its level.
- R3: In left-aligned mode (alignment input 0) the counter steps from 0 up to period−1 and then wraps to 0. One period spans period selected ticks, which is X × period master clocks for a tap of divisor X.
- R4: In center-aligned mode (alignment input 1) the counter steps up from 0 to period and then down to 0. One period spans 2 × period selected ticks.
- R5: In left-aligned mode with 0 < duty < period, the output sits at the polarity level for duty ticks of each period and at the opposite level for the rest.
- R6: In center-aligned mode with 0 < duty < period, the output sits at the polarity level for 2 × duty ticks of each period, centred on the period boundary.
- R7: An active duty of 0 holds the output at the inverse of the polarity. An active duty that is at least the active period holds the output at the polarity level.
- R8: New period, duty and alignment values take effect only at the next period-end strobe. The period in progress completes with the old values.
- R9: The period-end strobe is a single master-clock pulse that occurs only on a selected tick. Because the active period is zero after reset, the first selected tick after reset is a period end. An active period of 0 gives a period end on every selected tick with the counter held at 0.
- R10: The polarity input inverts the output: with polarity 0 the active portion is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| tapEn | input | NUM_TAPS (11) | Clock-enable taps from the shared prescaler; tap k pulses every 2^k cycles |
| clkSel | input | SEL_W (4) | Index of the tap that clocks this channel |
| centerMode | input | 1 | 0 = left-aligned, 1 = center-aligned; sampled at period end |
| polarity | input | 1 | Output level during the active portion |
| period | input | CNT_W (16) | Period value; sampled at period end |
| duty | input | CNT_W (16) | Duty value; sampled at period end |
| pwmOut | output | 1 | PWM waveform |
| periodEnd | output | 1 | One-cycle strobe at each period boundary |

## Verification
The assertions assume that the taps are ordinary clock enables: every tap is sampled at each master-clock edge, and the select input chooses one of them without further qualification. The assertions make no assumption about how often a tap pulses. They assume the configuration inputs may change in any cycle, which is why they check the latched values rather than the inputs. The stimulus changes configuration only at the falling clock edge. It drives the taps from a free-running binary divider, so each tap is a clean one-cycle pulse at its own power-of-two rate. It keeps every measured case within 0 < duty < period, except in the directed tests that target the constant-output and zero-period corners.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  // Strobes from the control to the datapath, valid for one cycle.
  typedef struct packed {
    logic inc;    // counter + 1
    logic dec;    // counter - 1
    logic clear;  // counter <- 0
    logic load;   // period boundary: latch new period, duty, alignment
  } cntStrobe_t;

endpackage

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_chan_pkg::*;
#(
  parameter int NUM_TAPS = 11,
  parameter int SEL_W    = 4,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TAPS-1:0] tapEn,
  input  logic [SEL_W-1:0]    clkSel,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [CNT_W-1:0]    actPeriod,
  input  logic                actCenter,
  output cntStrobe_t          strobe,
  output logic                dirUp,
  output logic                tick
);

  localparam int EXT_W = CNT_W + 1;

  logic [NUM_TAPS-1:0] selHit;
  logic [EXT_W-1:0]    cntPlusOne;
  logic                leftLast;
  logic                centerRising;
  logic                centerBottom;

  // Tap selector: one comparator per tap, an out-of-range select hits none.
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tapSel
    assign selHit[i] = (clkSel == SEL_W'(i)) && tapEn[i];
  end
  assign tick = |selHit;

  // Turnaround decisions.
  assign cntPlusOne   = {1'b0, cnt} + EXT_W'(1);
  assign leftLast     = cntPlusOne >= {1'b0, actPeriod};  // also true when period is 0
  assign centerRising = dirUp && (cnt < actPeriod);
  assign centerBottom = (cnt <= CNT_W'(1));

  always_comb begin
    strobe = '0;
    if (tick) begin
      if (!actCenter) begin
        if (leftLast) begin
          strobe.clear = 1'b1;
          strobe.load  = 1'b1;
        end else begin
          strobe.inc = 1'b1;
        end
      end else begin
        if (centerRising) begin
          strobe.inc = 1'b1;
        end else if (centerBottom) begin
          strobe.clear = 1'b1;
          strobe.load  = 1'b1;
        end else begin
          strobe.dec = 1'b1;
        end
      end
    end
  end

  // Direction state: up after each boundary, down once the top is passed.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirUp <= 1'b1;
    end else if (strobe.load) begin
      dirUp <= 1'b1;
    end else if (strobe.dec) begin
      dirUp <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_chan_dpath.sv
module pwm_chan_dpath
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic             dirUp,
  input  logic             centerMode,
  input  logic             polarity,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] actPeriod,
  output logic [CNT_W-1:0] actDuty,
  output logic             actCenter,
  output logic             pwmOut
);

  logic dutySat;
  logic belowDuty;
  logic activeLvl;

  // Channel counter.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.clear) begin
      cnt <= '0;
    end else if (strobe.inc) begin
      cnt <= cnt + CNT_W'(1);
    end else if (strobe.dec) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // Active configuration, refreshed only at a period boundary.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actPeriod <= '0;
      actDuty   <= '0;
      actCenter <= 1'b0;
    end else if (strobe.load) begin
      actPeriod <= period;
      actDuty   <= duty;
      actCenter <= centerMode;
    end
  end

  // Comparator: on the way down the duty value itself is still active,
  // so a center-aligned pulse spans 2 x duty ticks.
  assign dutySat   = (actDuty != '0) && (actDuty >= actPeriod);
  assign belowDuty = dirUp ? (cnt < actDuty) : (cnt <= actDuty);
  assign activeLvl = dutySat || belowDuty;
  assign pwmOut    = activeLvl ? polarity : ~polarity;

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int NUM_TAPS = 11,
  parameter int SEL_W    = 4,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TAPS-1:0] tapEn,
  input  logic [SEL_W-1:0]    clkSel,
  input  logic                centerMode,
  input  logic                polarity,
  input  logic [CNT_W-1:0]    period,
  input  logic [CNT_W-1:0]    duty,
  output logic                pwmOut,
  output logic                periodEnd
);

  cntStrobe_t       strobe;
  logic             dirUpQ;
  logic             tick;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] actPeriodQ;
  logic [CNT_W-1:0] actDutyQ;
  logic             actCenterQ;

  pwm_chan_ctrl #(
    .NUM_TAPS(NUM_TAPS),
    .SEL_W   (SEL_W),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tapEn    (tapEn),
    .clkSel   (clkSel),
    .cnt      (cntQ),
    .actPeriod(actPeriodQ),
    .actCenter(actCenterQ),
    .strobe   (strobe),
    .dirUp    (dirUpQ),
    .tick     (tick)
  );

  pwm_chan_dpath #(
    .CNT_W(CNT_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dirUp     (dirUpQ),
    .centerMode(centerMode),
    .polarity  (polarity),
    .period    (period),
    .duty      (duty),
    .cnt       (cntQ),
    .actPeriod (actPeriodQ),
    .actDuty   (actDutyQ),
    .actCenter (actCenterQ),
    .pwmOut    (pwmOut)
  );

  assign periodEnd = strobe.load;

endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int NUM_TAPS = 11,
  parameter int SEL_W    = 4,
  parameter int CNT_W    = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_TAPS-1:0] tapEn,
  input logic [SEL_W-1:0]    clkSel,
  input logic                polarity,
  input logic                pwmOut,
  input logic                periodEnd,
  input logic [CNT_W-1:0]    cnt,
  input logic [CNT_W-1:0]    actPeriod,
  input logic [CNT_W-1:0]    actDuty,
  input logic                actCenter
);

  logic selTick;
  always_comb begin
    selTick = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (clkSel == SEL_W'(i)) selTick = tapEn[i];
    end
  end

  assert_end_on_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |-> selTick);

  assert_stall_R2: assert property (@(posedge clk) disable iff (!rstN)
    !selTick |=> $stable(cnt));

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> (cnt == '0));

  assert_left_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    !actCenter |-> ((actPeriod == '0) ? (cnt == '0) : (cnt < actPeriod)));

  assert_left_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (selTick && !periodEnd && !actCenter) |=> (cnt == $past(cnt) + CNT_W'(1)));

  assert_center_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    actCenter |-> (cnt <= actPeriod));

  assert_hold_cfg_R8: assert property (@(posedge clk) disable iff (!rstN)
    !periodEnd |=> ($stable(actPeriod) && $stable(actDuty) && $stable(actCenter)));

  assert_duty_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (actDuty == '0) |-> (pwmOut != polarity));

endmodule

bind pwm_chan pwm_chan_chk #(
  .NUM_TAPS(NUM_TAPS),
  .SEL_W   (SEL_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tapEn    (tapEn),
  .clkSel   (clkSel),
  .polarity (polarity),
  .pwmOut   (pwmOut),
  .periodEnd(periodEnd),
  .cnt      (cntQ),
  .actPeriod(actPeriodQ),
  .actDuty  (actDutyQ),
  .actCenter(actCenterQ)
);

// File: tb/test_pwm_chan.sv
`timescale 1ns/1ps
module test_pwm_chan;

  localparam int NUM_TAPS = 11;
  localparam int SEL_W    = 4;
  localparam int CNT_W    = 16;
  localparam int WATCHDOG = 190000;

  typedef struct packed {
    logic [3:0]  sel;
    logic        center;
    logic        pol;
    logic [15:0] per;
    logic [15:0] dut;
  } cfg_t;

  localparam cfg_t VECS [8] = '{
    '{4'd0, 1'b0, 1'b1, 16'd10, 16'd3},
    '{4'd1, 1'b0, 1'b1, 16'd8,  16'd5},
    '{4'd3, 1'b0, 1'b0, 16'd6,  16'd2},
    '{4'd2, 1'b1, 1'b1, 16'd7,  16'd3},
    '{4'd0, 1'b1, 1'b0, 16'd5,  16'd1},
    '{4'd5, 1'b1, 1'b1, 16'd4,  16'd3},
    '{4'd8, 1'b0, 1'b1, 16'd3,  16'd1},
    '{4'd4, 1'b1, 1'b1, 16'd6,  16'd5}
  };

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [NUM_TAPS-1:0] tapEn;
  logic [SEL_W-1:0]    clkSel = '0;
  logic                centerMode = 1'b0;
  logic                polarity = 1'b1;
  logic [CNT_W-1:0]    period = '0;
  logic [CNT_W-1:0]    duty = '0;
  logic                pwmOut;
  logic                periodEnd;
  logic [9:0]          divCnt = '0;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  // Prescaler model: tap k pulses once every 2^k cycles.
  always_ff @(posedge clk) divCnt <= divCnt + 10'd1;
  always_comb begin
    tapEn[0] = 1'b1;
    for (int k = 1; k < NUM_TAPS; k++) begin
      tapEn[k] = ((divCnt & ((10'd1 << k) - 10'd1)) == 10'd0);
    end
  end

  pwm_chan #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W), .CNT_W(CNT_W)) i_pwm_chan (
    .clk(clk), .rstN(rstN), .tapEn(tapEn), .clkSel(clkSel),
    .centerMode(centerMode), .polarity(polarity), .period(period),
    .duty(duty), .pwmOut(pwmOut), .periodEnd(periodEnd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitEnd();
    for (int n = 0; n < 60000; n++) begin
      @(negedge clk);
      if (periodEnd) return;
    end
  endtask

  task automatic measure(input logic pol, output int hi, output int per);
    int lo;
    hi = 0; lo = 0;
    for (int n = 0; n < 60000 && pwmOut == pol; n++) @(negedge clk);
    for (int n = 0; n < 60000 && pwmOut != pol; n++) @(negedge clk);
    while (pwmOut == pol && hi < 60000) begin hi++; @(negedge clk); end
    while (pwmOut != pol && lo < 60000) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hi, per, n, cnt1, chg;
    logic last;

    // R1: reset state.
    repeat (4) @(negedge clk);
    check(pwmOut == 1'b0, "R1 output during reset", pwmOut, 0);
    clkSel = 4'd15;
    @(negedge clk); rstN = 1'b1;
    cnt1 = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (periodEnd) cnt1++;
      if (pwmOut != 1'b0) cnt1 += 100;
    end
    check(cnt1 == 0, "R1/R2 idle with unused select", cnt1, 0);

    // R9: first selected tick is a period end.
    period = 16'd6; duty = 16'd2; clkSel = 4'd0;
    #1;
    check(periodEnd == 1'b1, "R9 first tick ends period", periodEnd, 1);
    @(negedge clk);
    check(pwmOut == 1'b1 && periodEnd == 1'b0, "R5 active after load", pwmOut, 1);

    // R8: mid-period change waits for the boundary.
    waitEnd();
    n = 0;
    @(negedge clk); n++;
    @(negedge clk); n++;
    period = 16'd9; duty = 16'd4;
    while (!periodEnd && n < 1000) begin @(negedge clk); n++; end
    check(n == 6, "R8 old period completes", n, 6);
    n = 0;
    do begin @(negedge clk); n++; end while (!periodEnd && n < 1000);
    check(n == 9, "R8 new period after boundary", n, 9);

    // Table of configurations: R3, R4, R5, R6, R10, R2 prescaler choice.
    foreach (VECS[v]) begin
      int x, expHi, expPer;
      clkSel = VECS[v].sel; centerMode = VECS[v].center; polarity = VECS[v].pol;
      period = VECS[v].per; duty = VECS[v].dut;
      waitEnd(); waitEnd();
      x = 1 << VECS[v].sel;
      expPer = (VECS[v].center ? 2 : 1) * int'(VECS[v].per) * x;
      expHi  = (VECS[v].center ? 2 : 1) * int'(VECS[v].dut) * x;
      measure(VECS[v].pol, hi, per);
      check(per == expPer, VECS[v].center ? "R4 center period" : "R3 left period", per, expPer);
      check(hi == expHi, VECS[v].center ? "R6 center active time" : "R5 left active time", hi, expHi);
      if (!VECS[v].pol) check(hi == expHi, "R10 inverted polarity active low", hi, expHi);
    end

    // R9: zero period gives a period end on every tick.
    clkSel = 4'd0; centerMode = 1'b0; polarity = 1'b1; period = 16'd0; duty = 16'd0;
    waitEnd(); waitEnd();
    cnt1 = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (periodEnd) cnt1++; end
    check(cnt1 == 5, "R9 zero period strobes each tick", cnt1, 5);

    // R7: duty 0 gives a constant inactive level.
    period = 16'd5; duty = 16'd0;
    waitEnd(); waitEnd();
    cnt1 = 0;
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (pwmOut) cnt1++; end
    check(cnt1 == 0, "R7 duty zero constant", cnt1, 0);

    // R7: duty above the period gives a constant active level.
    duty = 16'd9;
    waitEnd(); waitEnd();
    cnt1 = 0;
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (pwmOut) cnt1++; end
    check(cnt1 == 15, "R7 duty above period constant", cnt1, 15);

    // R7: duty equal to the period in center mode is still constant.
    centerMode = 1'b1; duty = 16'd5;
    waitEnd(); waitEnd();
    cnt1 = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwmOut) cnt1++; end
    check(cnt1 == 20, "R7 center duty equals period constant", cnt1, 20);

    // R2: out-of-range select stops the channel.
    centerMode = 1'b0; duty = 16'd2;
    waitEnd(); waitEnd();
    @(negedge clk);
    clkSel = 4'd13;
    @(negedge clk);
    last = pwmOut; cnt1 = 0; chg = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (periodEnd) cnt1++;
      if (pwmOut != last) chg++;
    end
    check(cnt1 == 0, "R2 stopped channel has no period end", cnt1, 0);
    check(chg == 0, "R2 stopped channel holds output", chg, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule